// File: doc/BRIEF.md
# Register Rename with Branch Checkpoints

This block sits in the rename stage of an out-of-order core. Each cycle it takes at most one micro-op and translates its two architectural source specifiers and its destination specifier (x0 to x31) into indices of one unified physical register file. Two structures hold the state: a map table that gives the current physical register for each architectural register, and a free list of unused physical registers. A micro-op that writes a register receives a fresh physical register. It also reports the one it replaces, so that commit can hand that register back once the micro-op retires.

Every micro-op that is flagged as a branch takes a checkpoint slot. That slot records the map table, the free list and the set of older unresolved branches, as they stand just after the branch is renamed. Each renamed micro-op carries a branch mask with one bit for each unresolved branch it depends on. If the branch resolves correctly, its slot is freed and its bit is cleared. If it is mispredicted, the map table and the free list are put back from its slot in a single cycle. Registers that commit returned in the meantime stay free.

Top module: `rename_core`

## Requirements
- R1: After reset, architectural register xi maps to physical register i, physical registers 32 to NUM_PREGS-1 are free, no branch is live, and in_ready is high.
- R2: out_prs1 and out_prs2 give the current mapping of in_rs1 and in_rs2, read before the micro-op's own destination is applied.
- R3: A micro-op with in_rd_wen=1 and in_rd≠0 that fires gets the lowest-numbered free physical register on out_pdst, with the previous mapping of in_rd on out_stale_pdst. The map table then points in_rd at the new register, and that register leaves the free list from the next cycle.
- R4: x0 always reads as physical register 0. A micro-op with in_rd=0 or in_rd_wen=0 allocates nothing and shows 0 on out_pdst and out_stale_pdst.
- R5: in_ready is low exactly when a mispredict is presented in the same cycle, or the micro-op needs a destination and no register is free, or it is a branch and all NUM_BR slots are in use. A micro-op fires when in_valid and in_ready are both high; otherwise rename state is unchanged.
- R6: A firing branch gets the lowest-numbered free slot on out_br_tag. out_br_mask has bit i set while the branch in slot i is unresolved, and a branch's own bit is not in its own mask.
- R7: A correct resolve (brres_valid=1, brres_mispredict=0) frees slot brres_tag and clears that bit from every live mask, including the out_br_mask presented in the same cycle.
- R8: A mispredict on brres_tag restores, for the next cycle, the map table and free list as they stood right after that branch was renamed, and leaves live only the branches older than it.
- R9: A commit free (commit_free_valid=1, commit_free_preg≠0) makes that register allocatable from the next cycle, and it stays free across any later mispredict restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Micro-op present |
| in_ready | output | 1 | Rename can accept the micro-op this cycle |
| in_rs1 | input | 5 | First source architectural register |
| in_rs2 | input | 5 | Second source architectural register |
| in_rd | input | 5 | Destination architectural register |
| in_rd_wen | input | 1 | Micro-op writes in_rd |
| in_is_br | input | 1 | Micro-op is a branch that needs a checkpoint |
| out_prs1 | output | log2(NUM_PREGS) | Physical register for in_rs1 |
| out_prs2 | output | log2(NUM_PREGS) | Physical register for in_rs2 |
| out_pdst | output | log2(NUM_PREGS) | Newly allocated physical destination |
| out_stale_pdst | output | log2(NUM_PREGS) | Previous physical mapping of in_rd |
| out_br_tag | output | log2(NUM_BR) | Checkpoint slot given to a branch |
| out_br_mask | output | NUM_BR | Unresolved branches the micro-op depends on |
| commit_free_valid | input | 1 | Commit returns a physical register |
| commit_free_preg | input | log2(NUM_PREGS) | Register returned by commit |
| brres_valid | input | 1 | A branch resolves this cycle |
| brres_tag | input | log2(NUM_BR) | Slot of the resolving branch |
| brres_mispredict | input | 1 | The resolving branch was mispredicted |

## Verification
The hardest case to reach is a mispredict that arrives while the free list is empty and every checkpoint slot is in use, because the restore has to bring back all the registers allocated since the branch in one step. Directed stimulus gets there by renaming a branch and then enough writers to drain the free list. It then fills the remaining slots, mispredicts the oldest branch and checks that the next writer is given the first register that was drained. Random traffic afterwards mixes commits, correct resolves and mispredicts in the same cycles as renames. A bench reorder model then shows that registers freed by commit survive a restore and that resolves in the same cycle clear the mask bits.

// File: rtl/rn_pkg.sv
// Shared definitions for the rename block.
// Assumes a fixed architectural register file of 32 entries.
package rn_pkg;
    localparam int AREGS  = 32;
    localparam int AREG_W = 5;
    typedef logic [AREG_W-1:0] areg_t;
endpackage

// File: rtl/rn_prio_enc.sv
// Lowest-set-bit finder, used for the free list and for the checkpoint slots.
// Assumes W >= 2; idx is zero when nothing is set.
module rn_prio_enc #(
    parameter int W = 8,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             found
);
    // scan from the top so the lowest set index wins
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rn_maptable.sv
// Architectural-to-physical map table with one snapshot per checkpoint slot.
// Assumes wr_en is never raised for x0 and that restore and snapshot never coincide.
module rn_maptable
    import rn_pkg::*;
#(
    parameter int PREG_W = 6,
    parameter int NBR    = 4,
    localparam int TAG_W = $clog2(NBR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  areg_t             rs1,
    input  areg_t             rs2,
    input  areg_t             rd,
    output logic [PREG_W-1:0] prs1,
    output logic [PREG_W-1:0] prs2,
    output logic [PREG_W-1:0] stale,
    input  logic              wr_en,
    input  logic [PREG_W-1:0] wr_preg,
    input  logic              snap_en,
    input  logic [TAG_W-1:0]  snap_tag,
    input  logic              restore_en,
    input  logic [TAG_W-1:0]  restore_tag
);
    typedef logic [AREGS-1:0][PREG_W-1:0] map_t;

    map_t map_q;
    map_t map_nxt;
    map_t ckpt_q [NBR];

    // reads see the state before this micro-op's own write
    assign prs1  = map_q[rs1];
    assign prs2  = map_q[rs2];
    assign stale = map_q[rd];

    // map contents after the current micro-op is applied
    always_comb begin
        map_nxt = map_q;
        if (wr_en) map_nxt[rd] = wr_preg;
    end

    // live map: identity at reset, restore wins over rename
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < AREGS; i++) map_q[i] <= PREG_W'(i);
        end else if (restore_en) begin
            map_q <= ckpt_q[restore_tag];
        end else begin
            map_q <= map_nxt;
        end
    end

    // snapshot storage, written when a branch is renamed
    always_ff @(posedge clk) begin
        for (int b = 0; b < NBR; b++) begin
            if (snap_en && snap_tag == TAG_W'(b)) ckpt_q[b] <= map_nxt;
        end
    end
endmodule

// File: rtl/rn_freelist.sv
// Free-register bit vector with one snapshot per checkpoint slot.
// Commit frees are merged into every snapshot so a restore cannot lose them.
// Assumes register 0 is never freed and a freed register is not free already.
module rn_freelist
    import rn_pkg::*;
#(
    parameter int NPREG  = 64,
    parameter int NBR    = 4,
    localparam int PREG_W = $clog2(NPREG),
    localparam int TAG_W  = $clog2(NBR)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [NPREG-1:0]  free_vec,
    input  logic              alloc_en,
    input  logic [PREG_W-1:0] alloc_preg,
    input  logic              free_en,
    input  logic [PREG_W-1:0] free_preg,
    input  logic              snap_en,
    input  logic [TAG_W-1:0]  snap_tag,
    input  logic              restore_en,
    input  logic [TAG_W-1:0]  restore_tag
);
    localparam logic [NPREG-1:0] RST_FREE = ~NPREG'({AREGS{1'b1}});

    logic [NPREG-1:0] free_q;
    logic [NPREG-1:0] set_v;
    logic [NPREG-1:0] clr_v;
    logic [NPREG-1:0] vec_nxt;
    logic [NPREG-1:0] ckpt_q [NBR];

    assign free_vec = free_q;

    // one-hot masks for the allocated and the returned register
    always_comb begin
        clr_v = '0;
        set_v = '0;
        if (alloc_en) clr_v[alloc_preg] = 1'b1;
        if (free_en)  set_v[free_preg]  = 1'b1;
        vec_nxt = (free_q & ~clr_v) | set_v;
    end

    // live free vector: restore keeps this cycle's commit free
    always_ff @(posedge clk) begin
        if (!rst_n)          free_q <= RST_FREE;
        else if (restore_en) free_q <= ckpt_q[restore_tag] | set_v;
        else                 free_q <= vec_nxt;
    end

    // snapshots: taken on branch rename, otherwise absorb commit frees
    always_ff @(posedge clk) begin
        for (int b = 0; b < NBR; b++) begin
            if (snap_en && snap_tag == TAG_W'(b)) ckpt_q[b] <= vec_nxt;
            else                                  ckpt_q[b] <= ckpt_q[b] | set_v;
        end
    end
endmodule

// File: rtl/rename_core.sv
// Single-issue register rename with per-branch checkpoints of map and free list.
// Assumes NUM_PREGS > 32, NUM_BR >= 2, commit frees only retired stale registers,
// and brres_tag names a live branch whenever brres_valid is high.
module rename_core
    import rn_pkg::*;
#(
    parameter int NUM_PREGS = 64,
    parameter int NUM_BR    = 4,
    localparam int PREG_W   = $clog2(NUM_PREGS),
    localparam int TAG_W    = $clog2(NUM_BR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [4:0]        in_rs1,
    input  logic [4:0]        in_rs2,
    input  logic [4:0]        in_rd,
    input  logic              in_rd_wen,
    input  logic              in_is_br,
    output logic [PREG_W-1:0] out_prs1,
    output logic [PREG_W-1:0] out_prs2,
    output logic [PREG_W-1:0] out_pdst,
    output logic [PREG_W-1:0] out_stale_pdst,
    output logic [TAG_W-1:0]  out_br_tag,
    output logic [NUM_BR-1:0] out_br_mask,
    input  logic              commit_free_valid,
    input  logic [PREG_W-1:0] commit_free_preg,
    input  logic              brres_valid,
    input  logic [TAG_W-1:0]  brres_tag,
    input  logic              brres_mispredict
);
    logic [NUM_BR-1:0]    live_q;
    logic [NUM_BR-1:0]    snap_mask_q [NUM_BR];
    logic [NUM_BR-1:0]    ok_clr;
    logic [NUM_BR-1:0]    live_eff;
    logic [NUM_PREGS-1:0] free_vec;
    logic [PREG_W-1:0]    alloc_idx;
    logic                 alloc_ok;
    logic [TAG_W-1:0]     slot_idx;
    logic                 slot_ok;
    logic [PREG_W-1:0]    stale_raw;
    logic                 mispred;
    logic                 need_dest;
    logic                 fire;
    logic                 do_alloc;
    logic                 do_snap;
    logic                 free_en;

    // resolve decode and the live mask seen by this cycle's micro-op
    always_comb begin
        mispred = brres_valid && brres_mispredict;
        ok_clr  = '0;
        if (brres_valid && !brres_mispredict) ok_clr[brres_tag] = 1'b1;
        live_eff = live_q & ~ok_clr;
    end

    // handshake and the enables derived from it
    assign need_dest = in_rd_wen && (in_rd != '0);
    assign in_ready  = !mispred && !(need_dest && !alloc_ok) && !(in_is_br && !slot_ok);
    assign fire      = in_valid && in_ready;
    assign do_alloc  = fire && need_dest;
    assign do_snap   = fire && in_is_br;
    assign free_en   = commit_free_valid && (commit_free_preg != '0);

    rn_prio_enc #(.W(NUM_PREGS)) u_free_enc (
        .vec   (free_vec),
        .idx   (alloc_idx),
        .found (alloc_ok)
    );

    rn_prio_enc #(.W(NUM_BR)) u_slot_enc (
        .vec   (~live_q),
        .idx   (slot_idx),
        .found (slot_ok)
    );

    rn_maptable #(.PREG_W(PREG_W), .NBR(NUM_BR)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .rs1         (in_rs1),
        .rs2         (in_rs2),
        .rd          (in_rd),
        .prs1        (out_prs1),
        .prs2        (out_prs2),
        .stale       (stale_raw),
        .wr_en       (do_alloc),
        .wr_preg     (alloc_idx),
        .snap_en     (do_snap),
        .snap_tag    (slot_idx),
        .restore_en  (mispred),
        .restore_tag (brres_tag)
    );

    rn_freelist #(.NPREG(NUM_PREGS), .NBR(NUM_BR)) u_free (
        .clk         (clk),
        .rst_n       (rst_n),
        .free_vec    (free_vec),
        .alloc_en    (do_alloc),
        .alloc_preg  (alloc_idx),
        .free_en     (free_en),
        .free_preg   (commit_free_preg),
        .snap_en     (do_snap),
        .snap_tag    (slot_idx),
        .restore_en  (mispred),
        .restore_tag (brres_tag)
    );

    // outputs toward dispatch
    assign out_pdst       = need_dest ? alloc_idx : '0;
    assign out_stale_pdst = need_dest ? stale_raw : '0;
    assign out_br_tag     = slot_idx;
    assign out_br_mask    = live_eff;

    // live branch set, which doubles as the slot-busy vector
    always_ff @(posedge clk) begin
        if (!rst_n)       live_q <= '0;
        else if (mispred) live_q <= snap_mask_q[brres_tag];
        else if (do_snap) live_q <= live_eff | (NUM_BR'(1) << slot_idx);
        else              live_q <= live_eff;
    end

    // per-slot record of the branches older than the slot's branch
    always_ff @(posedge clk) begin
        for (int b = 0; b < NUM_BR; b++) begin
            if (do_snap && slot_idx == TAG_W'(b)) snap_mask_q[b] <= live_eff;
            else                                  snap_mask_q[b] <= snap_mask_q[b] & ~ok_clr;
        end
    end
endmodule

// File: rtl/rename_core_chk.sv
// Property checker for rename_core, attached by the bind at the end of this file.
// Looks at ports plus the live branch set and the free vector.
module rename_core_chk #(
    parameter int NUM_PREGS = 64,
    parameter int NUM_BR    = 4,
    localparam int PREG_W   = $clog2(NUM_PREGS),
    localparam int TAG_W    = $clog2(NUM_BR)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic [4:0]           in_rs1,
    input logic [4:0]           in_rs2,
    input logic [4:0]           in_rd,
    input logic                 in_rd_wen,
    input logic                 in_is_br,
    input logic [PREG_W-1:0]    out_prs1,
    input logic [PREG_W-1:0]    out_prs2,
    input logic [PREG_W-1:0]    out_pdst,
    input logic [TAG_W-1:0]     out_br_tag,
    input logic                 brres_valid,
    input logic [TAG_W-1:0]     brres_tag,
    input logic                 brres_mispredict,
    input logic [NUM_BR-1:0]    live_q,
    input logic [NUM_PREGS-1:0] free_vec
);
    logic fire_c;
    logic dest_c;
    assign fire_c = in_valid && in_ready;
    assign dest_c = in_rd_wen && (in_rd != 5'd0);

    a_r4_x0_src1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rs1 == 5'd0) |-> (out_prs1 == '0));
    a_r4_x0_src2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rs2 == 5'd0) |-> (out_prs2 == '0));
    a_r3_pdst_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_c && dest_c) |-> (out_pdst != '0));
    a_r3_alloc_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_c && dest_c) |=> !free_vec[$past(out_pdst)]);
    a_r6_tag_unused: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_c && in_is_br) |-> !live_q[out_br_tag]);
    a_r6_tag_live: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_c && in_is_br) |=> live_q[$past(out_br_tag)]);
    a_r7_resolve_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (brres_valid && !brres_mispredict) |=> !live_q[$past(brres_tag)]);
    a_r8_kill_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (brres_valid && brres_mispredict) |=> !live_q[$past(brres_tag)]);
    a_r5_block_on_mispredict: assert property (@(posedge clk) disable iff (!rst_n)
        (brres_valid && brres_mispredict) |-> !in_ready);
endmodule

bind rename_core rename_core_chk #(.NUM_PREGS(NUM_PREGS), .NUM_BR(NUM_BR)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .in_valid         (in_valid),
    .in_ready         (in_ready),
    .in_rs1           (in_rs1),
    .in_rs2           (in_rs2),
    .in_rd            (in_rd),
    .in_rd_wen        (in_rd_wen),
    .in_is_br         (in_is_br),
    .out_prs1         (out_prs1),
    .out_prs2         (out_prs2),
    .out_pdst         (out_pdst),
    .out_br_tag       (out_br_tag),
    .brres_valid      (brres_valid),
    .brres_tag        (brres_tag),
    .brres_mispredict (brres_mispredict),
    .live_q           (live_q),
    .free_vec         (free_vec)
);

// File: tb/tb_rename_core.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases, then seeded random traffic
// compared against a behavioural model with an in-order retire queue.
module tb_rename_core;
    localparam int NP = 64;
    localparam int NB = 4;
    localparam int PW = $clog2(NP);
    localparam int TW = $clog2(NB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [4:0]    in_rs1 = '0, in_rs2 = '0, in_rd = '0;
    logic          in_rd_wen = 1'b0, in_is_br = 1'b0;
    logic [PW-1:0] out_prs1, out_prs2, out_pdst, out_stale_pdst;
    logic [TW-1:0] out_br_tag;
    logic [NB-1:0] out_br_mask;
    logic          commit_free_valid = 1'b0;
    logic [PW-1:0] commit_free_preg = '0;
    logic          brres_valid = 1'b0;
    logic [TW-1:0] brres_tag = '0;
    logic          brres_mispredict = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rename_core #(.NUM_PREGS(NP), .NUM_BR(NB)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_rs1(in_rs1), .in_rs2(in_rs2), .in_rd(in_rd), .in_rd_wen(in_rd_wen),
        .in_is_br(in_is_br), .out_prs1(out_prs1), .out_prs2(out_prs2),
        .out_pdst(out_pdst), .out_stale_pdst(out_stale_pdst),
        .out_br_tag(out_br_tag), .out_br_mask(out_br_mask),
        .commit_free_valid(commit_free_valid), .commit_free_preg(commit_free_preg),
        .brres_valid(brres_valid), .brres_tag(brres_tag),
        .brres_mispredict(brres_mispredict)
    );

    // behavioural model state
    int          mmap [32];
    int          smap [NB][32];
    bit [NP-1:0] mfree;
    bit [NP-1:0] sfree [NB];
    bit [NP-1:0] mcommitted;
    bit [NB-1:0] mlive;
    bit [NB-1:0] smask [NB];
    bit          first_step;
    bit          after_mis;
    int          rob_stale [$];
    int          rob_mask [$];

    function automatic int low_free(bit [NP-1:0] f);
        for (int i = 0; i < NP; i++) if (f[i]) return i;
        return -1;
    endfunction

    function automatic int low_slot(bit [NB-1:0] l);
        for (int i = 0; i < NB; i++) if (!l[i]) return i;
        return -1;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) mmap[i] = i;
        mfree = '0;
        for (int i = 32; i < NP; i++) mfree[i] = 1'b1;
        mcommitted = '0;
        mlive = '0;
        first_step = 1'b1;
        after_mis = 1'b0;
    endtask

    // one cycle: drive after the falling edge, check, then advance the model
    task automatic step(input bit v, input int r1, input int r2, input int rd, input bit wen,
                        input bit br, input bit cv, input int cp, input bit bv, input int bt,
                        input bit bm);
        bit mis, nd, ex_ready, fire;
        bit [NB-1:0] okc;
        bit [NP-1:0] setv;
        int fi, si, old_rd;
        string lp;
        @(negedge clk);
        in_valid = v; in_rs1 = 5'(r1); in_rs2 = 5'(r2); in_rd = 5'(rd);
        in_rd_wen = wen; in_is_br = br;
        commit_free_valid = cv; commit_free_preg = PW'(cp);
        brres_valid = bv; brres_tag = TW'(bt); brres_mispredict = bm;
        #2;
        mis = bv && bm;
        okc = '0;
        if (bv && !bm) okc[bt] = 1'b1;
        nd = wen && (rd != 0);
        fi = low_free(mfree);
        si = low_slot(mlive);
        ex_ready = !mis && !(nd && fi < 0) && !(br && si < 0);
        chk(first_step ? "R1" : "R5", "in_ready", int'(in_ready), int'(ex_ready));
        fire = v && ex_ready;
        old_rd = mmap[rd];
        if (fire) begin
            lp = first_step ? "R1" : (after_mis ? "R8" : "R2");
            chk(r1 == 0 ? "R4" : lp, "prs1", int'(out_prs1), mmap[r1]);
            chk(r2 == 0 ? "R4" : lp, "prs2", int'(out_prs2), mmap[r2]);
            if (!nd)
                chk("R4", "pdst", int'(out_pdst), 0);
            else
                chk(mcommitted[fi] ? "R9" : (after_mis ? "R8" : "R3"), "pdst", int'(out_pdst), fi);
            chk(nd ? "R3" : "R4", "stale", int'(out_stale_pdst), nd ? old_rd : 0);
            chk(okc != 0 ? "R7" : "R6", "br_mask", int'(out_br_mask), int'(mlive & ~okc));
            if (br) chk("R6", "br_tag", int'(out_br_tag), si);
        end
        first_step = 1'b0;
        after_mis = mis;
        // model update
        setv = '0;
        if (cv && cp != 0) setv[cp] = 1'b1;
        if (fire && nd) begin
            mmap[rd] = fi;
            mfree[fi] = 1'b0;
            mcommitted[fi] = 1'b0;
        end
        mfree = mfree | setv;
        mcommitted = mcommitted | setv;
        for (int b = 0; b < NB; b++) begin
            sfree[b] = sfree[b] | setv;
            smask[b] = smask[b] & ~okc;
        end
        if (fire && br) begin
            for (int i = 0; i < 32; i++) smap[si][i] = mmap[i];
            sfree[si] = mfree;
            smask[si] = mlive & ~okc;
        end
        if (mis) begin
            for (int i = 0; i < 32; i++) mmap[i] = smap[bt][i];
            mfree = sfree[bt] | setv;
            mlive = smask[bt];
            for (int k = rob_mask.size() - 1; k >= 0; k--) begin
                if (((rob_mask[k] >> bt) & 1) != 0) begin
                    rob_mask.delete(k);
                    rob_stale.delete(k);
                end
            end
        end else begin
            for (int k = 0; k < rob_mask.size(); k++) rob_mask[k] = rob_mask[k] & ~int'(okc);
            if (fire) begin
                rob_stale.push_back(nd ? old_rd : 0);
                rob_mask.push_back(int'(mlive & ~okc));
            end
            mlive = mlive & ~okc;
            if (fire && br) mlive[si] = 1'b1;
        end
    endtask

    // watchdog: a hang counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        bit cv, bv, bm;
        int cp, bt;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: identity mapping after reset
        step(1, 5, 31, 0, 0, 0, 0, 0, 0, 0, 0);
        // R6: first branch takes slot 0
        step(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        // R3: drain the free list under that branch
        for (int i = 0; i < 32; i++) step(1, i, (i + 7) % 32, 1 + (i % 31), 1, 0, 0, 0, 0, 0, 0);
        // R5: writer stalls on empty free list; R4: non-writer still passes
        step(1, 3, 4, 9, 1, 0, 0, 0, 0, 0, 0);
        step(1, 3, 4, 0, 1, 0, 0, 0, 0, 0, 0);
        // R5: fill every slot, then a branch must stall
        for (int i = 0; i < 3; i++) step(1, 1, 2, 0, 0, 1, 0, 0, 0, 0, 0);
        step(1, 1, 2, 0, 0, 1, 0, 0, 0, 0, 0);
        // R8: mispredict the oldest branch with free list empty and slots full
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1);
        step(1, 1, 2, 1, 1, 0, 0, 0, 0, 0, 0);
        // R7: correct resolve in the same cycle as a new branch
        step(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 1, 0, 0, 1, 0, 0);
        step(1, 4, 5, 6, 1, 0, 0, 0, 1, 1, 0);

        // random traffic
        for (int n = 0; n < 20000; n++) begin
            cv = 1'b0; cp = 0; bv = 1'b0; bm = 1'b0; bt = 0;
            if (rob_stale.size() > 0 && rob_mask[0] == 0 && ($urandom % 2) == 0) begin
                cv = 1'b1;
                cp = rob_stale.pop_front();
                void'(rob_mask.pop_front());
            end
            if (mlive != 0 && ($urandom % 4) == 0) begin
                bv = 1'b1;
                bm = (($urandom % 4) == 0);
                bt = int'($urandom % NB);
                while (!mlive[bt]) bt = int'($urandom % NB);
            end
            step(($urandom % 4) != 0, int'($urandom % 32), int'($urandom % 32),
                 int'($urandom % 32), ($urandom % 4) != 0, ($urandom % 5) == 0,
                 cv, cp, bv, bt, bm);
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule